// File: doc/BRIEF.md
# Decimal Event Counter with Serial Result Readout

This block counts events in decimal. It is built as a chain of BCD decades. An event is counted on any clock edge where both the gate and the event input are high. When a transfer strobe arrives, all digits are copied in one step into a separate hold register. The hold register then acts as a shifter and presents the captured value to a display decoder one digit per clock, most significant digit first.

The live counter keeps running while the held value streams out, so the next measurement interval can begin at once. A clear input zeroes the live counter and its overflow flag and leaves the hold register alone. An overflow flag records that the top decade has carried out. The flag stays set until the next clear.

Top module: `bcd_event_counter`

## Requirements
- R1: After reset, `digit_valid_o` and `overflow_o` are 0. A transfer issued straight after reset reads out all-zero digits.
- R2: The count goes up by one only on an edge where `gate_i` and `event_i` are both 1. An event while the gate is low has no effect, and an open gate with no event has no effect.
- R3: Each digit holds a BCD value from 0 to 9. A digit at 9 that is incremented becomes 0 and carries one into the next more significant digit (1099 + 1 = 1100).
- R4: `overflow_o` rises on the edge where the top decade carries out of 9. At that edge the whole count wraps to zero. The flag then stays at 1 through further counting until a clear.
- R5: On the edge where `xfer_i` is 1, the hold register captures the count value that the live counter held just before that edge. On the next cycle `digit_valid_o` is 1.
- R6: After a transfer, `digit_o` shows the held digits for NUM_DIGITS consecutive cycles, with `digit_valid_o` high. The digits come most significant first, each as a 4-bit BCD value. After that, `digit_valid_o` returns to 0.
- R7: `clear_i` sets the live count and `overflow_o` to zero on the next edge. It does not change the held digits or a readout that is in progress.
- R8: A transfer that arrives during a readout restarts the readout from the most significant digit, using the newly captured count.
- R9: When transfer and clear occur on the same edge, the readout shows the count from before the clear, and the live counter restarts from zero. Clear takes priority over an event on that edge.
- R10: An event counted on the same edge as a transfer is missing from the held value but present in the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Enables counting of events while high |
| event_i | input | 1 | Event to count, sampled on each edge |
| clear_i | input | 1 | Zeroes the live count and the overflow flag |
| xfer_i | input | 1 | Captures the live count and starts a readout |
| digit_o | output | 4 | Current BCD digit of the readout |
| digit_valid_o | output | 1 | High while `digit_o` carries a readout digit |
| overflow_o | output | 1 | Sticky flag set when the top decade carries out |

## Verification
Three functions can meet on one edge: a transfer, counting, and a clear. The bench drives a transfer together with a counted event, then drives a transfer together with a clear. It judges each case by two readouts. The first must show the count from before the edge. The second, taken after the edge, must show the live count with the event included, or zero after the clear. A clear and a second transfer are also driven in the middle of a readout. In those cases the streamed digits must be untouched by the clear, and the second transfer must restart the readout at the most significant digit.

// File: rtl/bcd_evt_pkg.sv
package bcd_evt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t digit_o,
  output logic carry_o
);
  bcd_t digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       digit_q <= '0;
    else if (clr_i)    digit_q <= '0;
    else if (inc_i)    digit_q <= (digit_q == BCD_TOP) ? '0 : digit_q + 4'd1;
  end

  assign digit_o = digit_q;
  assign carry_o = inc_i && (digit_q == BCD_TOP);

  assert_digit_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_o <= BCD_TOP);
  assert_wrap_on_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o && !clr_i |=> digit_o == '0);
endmodule

// File: rtl/bcd_count_chain.sv
module bcd_count_chain
  import bcd_evt_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_i,
  input  logic                              inc_i,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits_o,
  output logic                              overflow_o
);
  logic [NUM_DIGITS:0] carry;
  logic                ovf_q;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_decade
    bcd_decade u_decade (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .inc_i   (carry[i]),
      .digit_o (digits_o[i]),
      .carry_o (carry[i+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= 1'b0;
    else if (clr_i)              ovf_q <= 1'b0;
    else if (carry[NUM_DIGITS])  ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;

  assert_hold_without_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(digits_o));
  assert_overflow_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry[NUM_DIGITS] && !clr_i |=> overflow_o && digits_o == '0);
  assert_overflow_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !clr_i |=> overflow_o);
  assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> digits_o == '0 && !overflow_o);
endmodule

// File: rtl/digit_serializer.sv
module digit_serializer
  import bcd_evt_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] par_i,
  output bcd_t                              digit_o,
  output logic                              valid_o
);
  localparam int CNT_W = $clog2(NUM_DIGITS + 1);

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] hold_q;
  logic [CNT_W-1:0]                   left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      hold_q <= par_i;
      left_q <= CNT_W'(NUM_DIGITS);
    end else if (left_q != '0) begin
      hold_q <= hold_q << DIGIT_W;  // next lower digit moves to the top
      left_q <= left_q - 1'b1;
    end
  end

  assign digit_o = hold_q[NUM_DIGITS-1];
  assign valid_o = (left_q != '0);

  assert_load_starts_msd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && digit_o == $past(par_i[NUM_DIGITS-1]));
  assert_idle_stays_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !valid_o |=> !valid_o);
  assert_digit_is_bcd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> digit_o <= BCD_TOP);
endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
  import bcd_evt_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gate_i,
  input  logic       event_i,
  input  logic       clear_i,
  input  logic       xfer_i,
  output logic [3:0] digit_o,
  output logic       digit_valid_o,
  output logic       overflow_o
);
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] live_digits;
  logic                               count_en;

  assign count_en = gate_i && event_i;

  bcd_count_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clear_i),
    .inc_i      (count_en),
    .digits_o   (live_digits),
    .overflow_o (overflow_o)
  );

  digit_serializer #(.NUM_DIGITS(NUM_DIGITS)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (xfer_i),
    .par_i   (live_digits),
    .digit_o (digit_o),
    .valid_o (digit_valid_o)
  );

  assert_snapshot_pre_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> digit_o == $past(live_digits[NUM_DIGITS-1]));
  assert_xfer_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && clear_i |=> digit_valid_o && live_digits == '0);
endmodule

// File: tb/bcd_event_counter_tb.sv
module bcd_event_counter_tb;
  localparam int NB = 8;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, gate, evt, clr, xfer;
  logic [3:0] dig, dig_s;
  logic       vld, vld_s, ovf, ovf_s;

  int     total = 0;
  int     bad   = 0;
  longint cnt_b = 0;
  longint cnt_s = 0;

  bcd_event_counter #(.NUM_DIGITS(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .event_i(evt), .clear_i(clr),
    .xfer_i(xfer), .digit_o(dig), .digit_valid_o(vld), .overflow_o(ovf));

  bcd_event_counter #(.NUM_DIGITS(NS)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .event_i(evt), .clear_i(clr),
    .xfer_i(xfer), .digit_o(dig_s), .digit_valid_o(vld_s), .overflow_o(ovf_s));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint dig_of(input longint v, input int n, input int k);
    longint p = 1;
    for (int i = 0; i < n - 1 - k; i++) p = p * 10;
    return (v / p) % 10;
  endfunction

  task automatic add_events(input int n);
    gate = 1'b1; evt = 1'b1;
    repeat (n) @(negedge clk);
    gate = 1'b0; evt = 1'b0;
    cnt_b = (cnt_b + n) % 100000000;
    cnt_s = (cnt_s + n) % 1000;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    cnt_b = 0; cnt_s = 0;
  endtask

  task automatic load(input bit with_clr, input bit with_evt);
    xfer = 1'b1; clr = with_clr; gate = with_evt; evt = with_evt;
    @(negedge clk);
    xfer = 1'b0; clr = 1'b0; gate = 1'b0; evt = 1'b0;
  endtask

  task automatic read_out(input longint exp_b, input longint exp_s, input int clr_at,
                          input string req);
    for (int k = 0; k < NB; k++) begin
      chk(vld == 1'b1, req, longint'(vld), 1);
      chk(longint'(dig) == dig_of(exp_b, NB, k), req, longint'(dig), dig_of(exp_b, NB, k));
      if (k < NS)
        chk(longint'(dig_s) == dig_of(exp_s, NS, k), req, longint'(dig_s), dig_of(exp_s, NS, k));
      if (k == NS) chk(vld_s == 1'b0, req, longint'(vld_s), 0);
      if (k == clr_at) do_clear();
      else @(negedge clk);
    end
    chk(vld == 1'b0, req, longint'(vld), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; gate = 1'b0; evt = 1'b0; clr = 1'b0; xfer = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0, "R1", longint'(vld), 0);
    chk(ovf == 1'b0 && ovf_s == 1'b0, "R1", longint'(ovf), 0);
    load(1'b0, 1'b0);
    read_out(0, 0, -1, "R1");
  endtask

  task automatic t_count();
    gate = 1'b0; evt = 1'b1;
    repeat (5) @(negedge clk);
    gate = 1'b1; evt = 1'b0;
    repeat (5) @(negedge clk);
    gate = 1'b0;
    load(1'b0, 1'b0);
    read_out(0, 0, -1, "R2");
    gate = 1'b1;
    for (int i = 0; i < 20; i++) begin
      evt = i[0];
      @(negedge clk);
    end
    gate = 1'b0; evt = 1'b0;
    cnt_b = 10; cnt_s = 10;
    load(1'b0, 1'b0);
    read_out(cnt_b, cnt_s, -1, "R2");
    add_events(1089);
    load(1'b0, 1'b0);
    read_out(1099, 99, -1, "R3");
    add_events(1);
    load(1'b0, 1'b0);
    read_out(1100, 100, -1, "R3");
  endtask

  task automatic t_overflow();
    do_clear();
    add_events(999);
    chk(ovf_s == 1'b0, "R4", longint'(ovf_s), 0);
    add_events(1);
    chk(ovf_s == 1'b1, "R4", longint'(ovf_s), 1);
    chk(ovf == 1'b0, "R4", longint'(ovf), 0);
    load(1'b0, 1'b0);
    read_out(cnt_b, cnt_s, -1, "R4");
    add_events(5);
    chk(ovf_s == 1'b1, "R4", longint'(ovf_s), 1);
    do_clear();
    chk(ovf_s == 1'b0, "R7", longint'(ovf_s), 0);
  endtask

  task automatic t_clear_mid_readout();
    do_clear();
    add_events(2345);
    load(1'b0, 1'b0);
    read_out(2345, 345, 4, "R7");
    load(1'b0, 1'b0);
    read_out(0, 0, -1, "R7");
  endtask

  task automatic t_restart();
    longint held;
    do_clear();
    add_events(321);
    load(1'b0, 1'b0);
    held = cnt_b;
    gate = 1'b1; evt = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(longint'(dig) == dig_of(held, NB, k), "R8", longint'(dig), dig_of(held, NB, k));
      @(negedge clk);
    end
    gate = 1'b0; evt = 1'b0;
    cnt_b = cnt_b + 4; cnt_s = cnt_s + 4;
    load(1'b0, 1'b0);
    read_out(cnt_b, cnt_s, -1, "R8");
  endtask

  task automatic t_same_edge();
    do_clear();
    add_events(57);
    load(1'b0, 1'b1);
    read_out(57, 57, -1, "R10");
    load(1'b1, 1'b0);
    read_out(58, 58, -1, "R9");
    load(1'b0, 1'b0);
    read_out(0, 0, -1, "R9");
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_overflow();
    t_clear_mid_readout();
    t_restart();
    t_same_edge();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule